// File: doc/BRIEF.md
# Scatter-Gather Sector DMA Engine

This block moves data between a sector-oriented storage device and system memory for a configurable number of independent channels. Software programs a channel with the address of a descriptor table in memory and then starts it. The channel reads descriptors one after another. Each descriptor names a memory region and a byte length. The channel fills or drains that region one 32-bit word at a time. On the device side it claims whole 512-byte sectors, and a sector may begin in one descriptor and end in the next.

Each channel has a control register, a status register and a table-base register, all on a small register bus. All channels share one request/acknowledge memory port, and a rotating-priority arbiter grants it one word transfer at a time. A channel stops when it finishes the descriptor that carries the end marker. It also stops when the device cannot offer or absorb the next sector, and when software clears its run bit.

Top module: `bmdma_engine`

## Requirements
- R1: Channel c has its registers at register address 8*c: control at offset 0, status at offset 2, table base at offset 4. A write to the table base stores the value with bits 1:0 forced to zero, and reads return the stored value.
- R2: Writing control bit 0 as 1 while that bit is clear sets status bit 0 (busy). The channel then reads the descriptor at the table base: first the word at the base, then the word at base+4.
- R3: Descriptor word 0 is the region address, with bits 1:0 ignored. In word 1, bits 15:0 hold the byte count, which is moved as count/4 words, and a count of 0 means 65536 bytes. Bit 31 of word 1 marks the final descriptor.
- R4: With control bit 3 set, each word taken from the device (dev_pop) is written to consecutive ascending memory addresses of the region. With bit 3 clear, words read from consecutive addresses are handed to the device (dev_push, dev_wdata).
- R5: Before each group of 128 words (one sector) the channel requires dev_sec_ok and pulses dev_sec_take once. A partly used sector continues into the next descriptor.
- R6: If a new sector is needed while dev_sec_ok is low, status bit 0 clears and status bits 1 (error) and 2 (interrupt) set in the same cycle. The channel then issues no further memory requests.
- R7: After a non-final descriptor, the next descriptor is fetched 8 bytes further on. After the final descriptor, busy clears and the interrupt bit sets, with the error bit unchanged.
- R8: Status bits 1 and 2 are cleared by writing 1 to them. Writing status bit 0 has no effect.
- R9: Writing control bit 0 as 0 while it is set stops the channel at once. Busy clears, the interrupt bit stays clear, and memory requests stop.
- R10: A memory request keeps mem_req, mem_addr and mem_we steady until mem_ack, unless a register write intervenes. After each completed transfer, the grant rotates to the next channel.
- R11: Control bit 3 is ignored by writes made while control bit 0 is set and stays set.
- R12: After reset all registers read zero and mem_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NUM_CH)+3 | Register address (channel, offset) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| dev_sec_ok | input | NUM_CH | Device can supply/accept a full sector |
| dev_sec_take | output | NUM_CH | Channel claims one sector |
| dev_rdata | input | NUM_CH*32 | Head word from the device, per channel |
| dev_pop | output | NUM_CH | Head word consumed |
| dev_wdata | output | 32 | Word handed to the device |
| dev_push | output | NUM_CH | dev_wdata is valid for that channel |

## Verification
The assertions check on every cycle that a pending memory request is held steady, that only one channel sees an acknowledge, that a sector is claimed only when offered, that device pops and pushes coincide with memory writes and reads, and that busy falls only together with an interrupt or right after a register write. The bench scenarios alone show the addresses and data of whole transfers: two descriptors sharing a sector, a 64 KiB zero-count descriptor running alongside another channel, a sector shortfall, a stop in mid-run, and the register access rules.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam logic [2:0] OFS_CTL = 3'd0;
  localparam logic [2:0] OFS_STS = 3'd2;
  localparam logic [2:0] OFS_TBL = 3'd4;
  localparam int CTL_RUN = 0;
  localparam int CTL_DIR = 3;
  localparam int STS_BUSY = 0;
  localparam int STS_ERR  = 1;
  localparam int STS_INT  = 2;

  typedef enum logic [2:0] {
    CH_IDLE,
    CH_GET_ADR,
    CH_GET_LEN,
    CH_MOVE,
    CH_HALT
  } ch_state_e;
endpackage

// File: rtl/bmdma_rst_sync.sv
module bmdma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bmdma_arb.sv
module bmdma_arb #(
  parameter int N = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N-1:0]                      req,
  input  logic                              ack,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] sel,
  output logic                              vld
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          own_vld_q, own_vld_n;
  logic [IW-1:0] own_q, own_n;
  logic [IW-1:0] prio_q, prio_n;
  logic [IW-1:0] pick;
  logic          found;
  logic          keep;
  int            idx;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = 0;
    for (int o = 0; o < N; o++) begin
      idx = (int'(prio_q) + o) % N;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
    keep = own_vld_q && req[own_q];
    sel  = keep ? own_q : pick;
    vld  = keep || found;
  end

  always_comb begin
    own_vld_n = vld && !ack;
    own_n     = vld ? sel : own_q;
    prio_n    = prio_q;
    if (vld && ack) begin
      prio_n = (int'(sel) == N - 1) ? '0 : sel + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld_q <= 1'b0;
      own_q     <= '0;
      prio_q    <= '0;
    end else begin
      own_vld_q <= own_vld_n;
      own_q     <= own_n;
      prio_q    <= prio_n;
    end
  end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
#(
  parameter int AW           = 32,
  parameter int LEN_W        = 16,
  parameter int SECTOR_BYTES = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic          wr_sts,
  input  logic          wr_tbl,
  input  logic [31:0]   wdata,
  output logic [31:0]   ctl_rd,
  output logic [31:0]   sts_rd,
  output logic [31:0]   tbl_rd,
  output logic          busy_o,
  output logic          err_o,
  output logic          int_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [31:0]   mwdata_o,
  input  logic          ack_i,
  input  logic [31:0]   mrdata_i,
  input  logic          sec_ok_i,
  output logic          sec_take_o,
  input  logic [31:0]   dev_rdata_i,
  output logic          pop_o,
  output logic          push_o
);
  localparam int WB        = 4;
  localparam int WSH       = 2;
  localparam int SEC_WORDS = SECTOR_BYTES / WB;
  localparam int SEC_CW    = $clog2(SEC_WORDS + 1);
  localparam int WL_W      = LEN_W - WSH + 1;
  localparam int MAX_WORDS = 2 ** (LEN_W - WSH);
  localparam logic [AW-1:0] DESC_STEP = AW'(2 * WB);

  ch_state_e         st_q, st_n;
  logic              run_q, run_n;
  logic              dir_q, dir_n;
  logic              busy_q, busy_n;
  logic              err_q, err_n;
  logic              int_q, int_n;
  logic [AW-1:0]     tbl_q, tbl_n;
  logic [AW-1:0]     cur_q, cur_n;
  logic [AW-1:0]     adr_q, adr_n;
  logic [WL_W-1:0]   wl_q, wl_n;
  logic [SEC_CW-1:0] sec_q, sec_n;
  logic              last_q, last_n;
  logic [LEN_W-1:0]  len_f;

  assign len_f = mrdata_i[LEN_W-1:0];

  always_comb begin
    st_n   = st_q;
    run_n  = run_q;
    dir_n  = dir_q;
    busy_n = busy_q;
    err_n  = err_q;
    int_n  = int_q;
    tbl_n  = tbl_q;
    cur_n  = cur_q;
    adr_n  = adr_q;
    wl_n   = wl_q;
    sec_n  = sec_q;
    last_n = last_q;

    req_o      = 1'b0;
    we_o       = 1'b0;
    addr_o     = cur_q;
    mwdata_o   = dev_rdata_i;
    sec_take_o = 1'b0;
    pop_o      = 1'b0;
    push_o     = 1'b0;

    if (wr_sts) begin
      if (wdata[STS_ERR]) err_n = 1'b0;
      if (wdata[STS_INT]) int_n = 1'b0;
    end
    if (wr_tbl) begin
      tbl_n = {wdata[AW-1:2], 2'b00};
    end

    unique case (st_q)
      CH_GET_ADR: begin
        req_o  = 1'b1;
        addr_o = cur_q;
        if (ack_i) begin
          adr_n = {mrdata_i[AW-1:2], 2'b00};
          st_n  = CH_GET_LEN;
        end
      end
      CH_GET_LEN: begin
        req_o  = 1'b1;
        addr_o = cur_q + AW'(WB);
        if (ack_i) begin
          wl_n   = (len_f == '0) ? WL_W'(MAX_WORDS) : WL_W'(len_f[LEN_W-1:WSH]);
          last_n = mrdata_i[31];
          st_n   = CH_MOVE;
        end
      end
      CH_MOVE: begin
        if (wl_q == '0) begin
          if (last_q) begin
            busy_n = 1'b0;
            int_n  = 1'b1;
            st_n   = CH_HALT;
          end else begin
            cur_n = cur_q + DESC_STEP;
            st_n  = CH_GET_ADR;
          end
        end else if (sec_q == '0) begin
          if (sec_ok_i) begin
            sec_take_o = 1'b1;
            sec_n      = SEC_CW'(SEC_WORDS);
          end else begin
            busy_n = 1'b0;
            err_n  = 1'b1;
            int_n  = 1'b1;
            st_n   = CH_HALT;
          end
        end else begin
          req_o  = 1'b1;
          we_o   = dir_q;
          addr_o = adr_q;
          if (ack_i) begin
            adr_n  = adr_q + AW'(WB);
            wl_n   = wl_q - 1'b1;
            sec_n  = sec_q - 1'b1;
            pop_o  = dir_q;
            push_o = !dir_q;
          end
        end
      end
      default: ;
    endcase

    if (wr_ctl) begin
      if (wdata[CTL_RUN] && !run_q) begin
        run_n  = 1'b1;
        dir_n  = wdata[CTL_DIR];
        busy_n = 1'b1;
        cur_n  = tbl_q;
        sec_n  = '0;
        st_n   = CH_GET_ADR;
      end else if (!wdata[CTL_RUN] && run_q) begin
        run_n  = 1'b0;
        busy_n = 1'b0;
        st_n   = CH_IDLE;
      end else if (!run_q) begin
        dir_n = wdata[CTL_DIR];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      run_q  <= 1'b0;
      dir_q  <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      int_q  <= 1'b0;
      tbl_q  <= '0;
      cur_q  <= '0;
      adr_q  <= '0;
      wl_q   <= '0;
      sec_q  <= '0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      run_q  <= run_n;
      dir_q  <= dir_n;
      busy_q <= busy_n;
      err_q  <= err_n;
      int_q  <= int_n;
      tbl_q  <= tbl_n;
      cur_q  <= cur_n;
      adr_q  <= adr_n;
      wl_q   <= wl_n;
      sec_q  <= sec_n;
      last_q <= last_n;
    end
  end

  always_comb begin
    ctl_rd          = '0;
    ctl_rd[CTL_RUN] = run_q;
    ctl_rd[CTL_DIR] = dir_q;
    sts_rd           = '0;
    sts_rd[STS_BUSY] = busy_q;
    sts_rd[STS_ERR]  = err_q;
    sts_rd[STS_INT]  = int_q;
    tbl_rd = 32'(tbl_q);
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;
  assign int_o  = int_q;
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
  import bmdma_pkg::*;
#(
  parameter int NUM_CH       = 2,
  parameter int AW           = 32,
  parameter int LEN_W        = 16,
  parameter int SECTOR_BYTES = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [$clog2(NUM_CH)+2:0]  reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [AW-1:0]              mem_addr,
  output logic [31:0]                mem_wdata,
  input  logic                       mem_ack,
  input  logic [31:0]                mem_rdata,
  input  logic [NUM_CH-1:0]          dev_sec_ok,
  output logic [NUM_CH-1:0]          dev_sec_take,
  input  logic [NUM_CH*32-1:0]       dev_rdata,
  output logic [NUM_CH-1:0]          dev_pop,
  output logic [31:0]                dev_wdata,
  output logic [NUM_CH-1:0]          dev_push
);
  localparam int CW = $clog2(NUM_CH);
  localparam int IW = (NUM_CH > 1) ? CW : 1;

  logic                        rst_ns;
  logic [IW-1:0]               sel;
  logic                        sel_vld;
  logic [NUM_CH-1:0]           ch_req;
  logic [NUM_CH-1:0]           ch_we;
  logic [NUM_CH-1:0][AW-1:0]   ch_addr;
  logic [NUM_CH-1:0][31:0]     ch_wdata;
  logic [NUM_CH-1:0]           ch_ack;
  logic [NUM_CH-1:0][31:0]     ctl_rd, sts_rd, tbl_rd;
  logic [NUM_CH-1:0]           st_busy, st_err, st_int;
  logic [CW-1:0]               rsel;
  logic [2:0]                  rofs;

  assign rsel = reg_addr[CW+2:3];
  assign rofs = reg_addr[2:0];

  bmdma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  bmdma_arb #(.N(NUM_CH)) u_arb (
    .clk   (clk),
    .rst_n (rst_ns),
    .req   (ch_req),
    .ack   (mem_ack),
    .sel   (sel),
    .vld   (sel_vld)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit       = reg_we && (int'(rsel) == c);
    assign ch_ack[c] = mem_ack && sel_vld && (int'(sel) == c);

    bmdma_chan #(
      .AW           (AW),
      .LEN_W        (LEN_W),
      .SECTOR_BYTES (SECTOR_BYTES)
    ) u_ch (
      .clk         (clk),
      .rst_n       (rst_ns),
      .wr_ctl      (hit && rofs == OFS_CTL),
      .wr_sts      (hit && rofs == OFS_STS),
      .wr_tbl      (hit && rofs == OFS_TBL),
      .wdata       (reg_wdata),
      .ctl_rd      (ctl_rd[c]),
      .sts_rd      (sts_rd[c]),
      .tbl_rd      (tbl_rd[c]),
      .busy_o      (st_busy[c]),
      .err_o       (st_err[c]),
      .int_o       (st_int[c]),
      .req_o       (ch_req[c]),
      .we_o        (ch_we[c]),
      .addr_o      (ch_addr[c]),
      .mwdata_o    (ch_wdata[c]),
      .ack_i       (ch_ack[c]),
      .mrdata_i    (mem_rdata),
      .sec_ok_i    (dev_sec_ok[c]),
      .sec_take_o  (dev_sec_take[c]),
      .dev_rdata_i (dev_rdata[c*32 +: 32]),
      .pop_o       (dev_pop[c]),
      .push_o      (dev_push[c])
    );
  end

  always_comb begin
    mem_req   = sel_vld;
    mem_we    = ch_we[sel];
    mem_addr  = ch_addr[sel];
    mem_wdata = ch_wdata[sel];
    dev_wdata = mem_rdata;
  end

  always_comb begin
    unique case (rofs)
      OFS_CTL: reg_rdata = ctl_rd[rsel];
      OFS_STS: reg_rdata = sts_rd[rsel];
      OFS_TBL: reg_rdata = tbl_rd[rsel];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bmdma_engine_chk.sv
module bmdma_engine_chk #(
  parameter int NUM_CH = 2,
  parameter int AW     = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      reg_we,
  input logic [$clog2(NUM_CH)+2:0] reg_addr,
  input logic [31:0]               reg_rdata,
  input logic                      mem_req,
  input logic                      mem_we,
  input logic [AW-1:0]             mem_addr,
  input logic                      mem_ack,
  input logic [NUM_CH-1:0]         dev_sec_ok,
  input logic [NUM_CH-1:0]         dev_sec_take,
  input logic [NUM_CH-1:0]         dev_pop,
  input logic [NUM_CH-1:0]         dev_push,
  input logic [NUM_CH-1:0]         ch_ack,
  input logic [NUM_CH-1:0]         st_busy,
  input logic [NUM_CH-1:0]         st_err,
  input logic [NUM_CH-1:0]         st_int
);
  AST_TBL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[2:0] == 3'd4) |-> (reg_rdata[1:0] == 2'b00)); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !reg_we) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

  AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_ack)); // R10

  AST_POP_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_pop) |-> (mem_req && mem_ack && mem_we)); // R4

  AST_PUSH_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_push) |-> (mem_req && mem_ack && !mem_we)); // R4

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    AST_TAKE_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
      dev_sec_take[c] |-> dev_sec_ok[c]); // R5

    AST_ERR_RAISES_INT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_err[c]) |-> (st_int[c] && !st_busy[c])); // R6

    AST_BUSY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_busy[c]) |-> (st_int[c] || $past(reg_we))); // R7
  end
endmodule

bind bmdma_engine bmdma_engine_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_ack      (mem_ack),
  .dev_sec_ok   (dev_sec_ok),
  .dev_sec_take (dev_sec_take),
  .dev_pop      (dev_pop),
  .dev_push     (dev_push),
  .ch_ack       (ch_ack),
  .st_busy      (st_busy),
  .st_err       (st_err),
  .st_int       (st_int)
);

// File: tb/tb_bmdma_engine.sv
module tb_bmdma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  dev_sec_ok, dev_sec_take, dev_pop, dev_push;
  logic [63:0] dev_rdata;
  logic [31:0] dev_wdata;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int pop0 = 0, push1 = 0, take0 = 0, take1 = 0;
  int pop_base = 0;
  int budget0 = 1000;
  int mode = 0;
  int tr0 = 0;
  int req_cnt = 0;
  logic [31:0] tr0_last = '0;
  logic [31:0] tbl [0:63];

  always #2.5 clk = ~clk;

  bmdma_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dev_sec_ok(dev_sec_ok),
    .dev_sec_take(dev_sec_take), .dev_rdata(dev_rdata), .dev_pop(dev_pop),
    .dev_wdata(dev_wdata), .dev_push(dev_push)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] exp_addr0(input int k);
    if (mode == 0) return (k < 192) ? 32'h2000 + 32'(4 * k) : 32'h3000 + 32'(4 * (k - 192));
    else if (mode == 1) return 32'h4000 + 32'(4 * k);
    else return 32'h5000 + 32'(4 * k);
  endfunction

  assign mem_ack    = mem_req && ((cyc % 4) != 3);
  assign mem_rdata  = (mem_addr >= 32'h1000 && mem_addr < 32'h1100) ? tbl[mem_addr[7:2]] : pat(mem_addr);
  assign dev_rdata  = {32'hB000_0000, 32'hA000_0000 + 32'(pop0)};
  assign dev_sec_ok = {1'b1, take0 < budget0};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      pop0  <= pop0 + int'(dev_pop[0]);
      push1 <= push1 + int'(dev_push[1]);
      take0 <= take0 + int'(dev_sec_take[0]);
      take1 <= take1 + int'(dev_sec_take[1]);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) req_cnt++;
      if (mem_req && mem_ack && mem_we) begin
        n_chk++;
        if (mem_addr !== exp_addr0(pop0 - pop_base) || mem_wdata !== 32'hA000_0000 + 32'(pop0) || !dev_pop[0]) begin
          n_fail++;
          $display("FAIL R4 device-to-memory word: addr %h data %h pop %b, expected addr %h data %h pop 1",
                   mem_addr, mem_wdata, dev_pop[0], exp_addr0(pop0 - pop_base), 32'hA000_0000 + 32'(pop0));
        end
      end
      if (dev_push[1]) begin
        n_chk++;
        if (dev_wdata !== pat(32'h10000 + 32'(4 * push1))) begin
          n_fail++;
          $display("FAIL R4 memory-to-device word %0d: got %h expected %h",
                   push1, dev_wdata, pat(32'h10000 + 32'(4 * push1)));
        end
      end
      if (mem_req && mem_ack && !mem_we && mem_addr[31:4] == 28'h100) begin
        tr0++;
        tr0_last = mem_addr;
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input logic [3:0] sts_a);
    logic [31:0] v;
    v = 32'h1;
    while (v[0]) begin
      repeat (10) @(posedge clk);
      rd(sts_a, v);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s0, t0;
    for (int i = 0; i < 64; i++) tbl[i] = '0;
    tbl[0]  = 32'h2000; tbl[1]  = 32'h0000_0300;
    tbl[2]  = 32'h3000; tbl[3]  = 32'h8000_0100;
    tbl[16] = 32'h1_0000; tbl[17] = 32'h8000_0000;
    tbl[32] = 32'h4000; tbl[33] = 32'h8000_0400;
    tbl[48] = 32'h5000; tbl[49] = 32'h8000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk("R12 mem_req after reset", {31'b0, mem_req}, 32'h0);
    for (int a = 0; a < 16; a += 2) begin
      rd(4'(a), v);
      chk("R12 register after reset", v, 32'h0);
    end

    // R1 table base alignment
    wr(4'd4, 32'h1003);
    rd(4'd4, v);
    chk("R1 table base low bits forced to zero", v, 32'h1000);
    wr(4'd12, 32'h1042);
    rd(4'd12, v);
    chk("R1 channel 1 table base", v, 32'h1040);

    // R2 R3 R4 R5 R7 R10: both channels concurrently
    mode = 0; pop_base = pop0; tr0 = 0;
    wr(4'd8, 32'h1);
    wr(4'd0, 32'h9);
    rd(4'd2, v);
    chk("R2 busy set after start", v & 32'h1, 32'h1);
    wait_idle(4'd2);
    wait_idle(4'd10);
    rd(4'd2, v);
    chk("R7 final descriptor: busy clear, interrupt set", v, 32'h4);
    chk("R5 words moved on channel 0 spanning descriptors", 32'(pop0 - pop_base), 32'd256);
    chk("R5 sectors claimed on channel 0", 32'(take0), 32'd2);
    chk("R2 descriptor words read from table", 32'(tr0), 32'd4);
    chk("R7 next descriptor 8 bytes further", tr0_last, 32'h100C);
    rd(4'd10, v);
    chk("R3 zero-count descriptor completes", v, 32'h4);
    chk("R3 65536 bytes moved to device", 32'(push1), 32'd16384);
    chk("R5 sectors claimed on channel 1", 32'(take1), 32'd128);

    // R6 sector shortfall, R8 status clearing
    wr(4'd0, 32'h0);
    wr(4'd2, 32'h6);
    wr(4'd4, 32'h1080);
    mode = 1; pop_base = pop0; t0 = take0; budget0 = take0 + 1;
    wr(4'd0, 32'h9);
    wait_idle(4'd2);
    rd(4'd2, v);
    chk("R6 shortfall: error and interrupt, not busy", v, 32'h6);
    chk("R6 words moved before shortfall", 32'(pop0 - pop_base), 32'd128);
    chk("R6 one sector claimed", 32'(take0 - t0), 32'd1);
    s0 = req_cnt;
    repeat (20) @(negedge clk);
    chk("R6 no requests after halt", 32'(req_cnt - s0), 32'd0);
    wr(4'd2, 32'h3);
    rd(4'd2, v);
    chk("R8 write-one clears error only", v, 32'h4);
    wr(4'd2, 32'h4);
    rd(4'd2, v);
    chk("R8 write-one clears interrupt", v, 32'h0);
    wr(4'd2, 32'h1);
    rd(4'd2, v);
    chk("R8 busy bit not writable", v, 32'h0);

    // R11 direction ignored while running, R9 stop
    wr(4'd0, 32'h0);
    wr(4'd4, 32'h10C0);
    mode = 2; pop_base = pop0; budget0 = 100000;
    wr(4'd0, 32'h9);
    repeat (200) @(negedge clk);
    wr(4'd0, 32'h1);
    rd(4'd0, v);
    chk("R11 direction bit kept while running", v, 32'h9);
    chk("R9 channel made progress before stop", {31'b0, (pop0 - pop_base) > 20}, 32'h1);
    wr(4'd0, 32'h8);
    rd(4'd2, v);
    chk("R9 stop clears busy without interrupt", v, 32'h0);
    s0 = req_cnt;
    repeat (20) @(negedge clk);
    chk("R9 no requests after stop", 32'(req_cnt - s0), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule